// File: doc/BRIEF.md
# Sign-Extending Shift Register with Shared Parallel Pins

This block is an eight-stage register that shifts toward its low end and shares one set of parallel data pins between loading and reading back. Stage A sits at bit `WIDTH-1` and stage H at bit 0. On each rising clock edge the register holds, loads all stages in parallel from the pins, or shifts one place toward bit 0. When it shifts, the new top bit is either a serial bit chosen from two inputs or a copy of the current top bit. The copy keeps the sign of a two's-complement value, so a sign-extend shift is an arithmetic right shift. A low level on the clear input zeroes every stage at once, without waiting for a clock edge.

The shared pins appear as three separate signals: a data-in bus, a data-out bus and a per-pin drive enable. A pad wrapper in the enclosing design can turn these into real bidirectional pins. The drive enable is low whenever the pins are switched off or the block is in parallel-load mode. Switching the pins off never stops the register from working. A separate serial output always shows the bottom stage. Parallel software tests and bus-side loads use the pins. Serialisers and arithmetic shifters use the shift modes.

Top module: `sext_shreg`

## Requirements
- R1: When `clr_n` is low, every stage reads 0 on `pin_out` at once, with no clock edge needed. This holds whatever `stall`, `shift_sel` and `pin_off` are.
- R2: When `stall` is 1 and `clr_n` is high, a rising edge leaves the register contents unchanged.
- R3: When `stall`=0, `shift_sel`=1 and `sext_n`=1, a rising edge sets bit `WIDTH-1` to the selected serial bit, and each bit i below it takes the old value of bit i+1.
- R4: In the shift of R3, the serial bit is `ser_in0` when `src_sel`=0 and `ser_in1` when `src_sel`=1.
- R5: When `stall`=0, `shift_sel`=1 and `sext_n`=0, a rising edge shifts as in R3, but bit `WIDTH-1` keeps its own old value. Both serial inputs are ignored.
- R6: When `stall`=0 and `shift_sel`=0, a rising edge loads `pin_in[i]` into bit i for every i.
- R7: While `stall`=0 and `shift_sel`=0, all bits of `pin_oe` are 0, whatever `pin_off` is, including while `clr_n` is low.
- R8: When `pin_off`=1, all bits of `pin_oe` are 0, while holding, shifting, loading and clearing work as usual.
- R9: `pin_out` always carries the register contents. When `pin_off`=0 and the block is not in load mode, all bits of `pin_oe` are 1.
- R10: `tail_out` always equals bit 0 of the register, whatever `pin_off` is.
- R11: Clear overrides every clocked mode, including across rising edges. The first rising edge after `clr_n` returns high applies the mode selected at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register updates on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| stall | input | 1 | 1 = hold contents |
| shift_sel | input | 1 | 1 = shift modes, 0 = parallel load (when not stalled) |
| sext_n | input | 1 | 0 = sign-extend shift, 1 = serial shift |
| src_sel | input | 1 | Serial source select: 0 = ser_in0, 1 = ser_in1 |
| ser_in0 | input | 1 | Serial data source 0 |
| ser_in1 | input | 1 | Serial data source 1 |
| pin_off | input | 1 | 1 = release all shared pins |
| pin_in | input | WIDTH | Data seen on the shared pins |
| pin_out | output | WIDTH | Register contents offered to the pins |
| pin_oe | output | WIDTH | Per-pin drive enable |
| tail_out | output | 1 | Serial output, bit 0 of the register |

## Verification
The bench goes after the corner cases that are easy to get wrong. A clear that waited for a clock would leave non-zero data visible between edges. Pins that followed only `pin_off` would drive against incoming data during a load. A sign-extend shift that pulled from the serial mux would turn negative values positive whenever the serial bit was 0. A serial output gated by `pin_off` would go silent while the pins are released. The bench also holds clear across a load edge and then checks that the first edge after release does a shift, which catches a clear with too little priority or a mode that was latched while clear was low. A long stretch of random modes is compared against an independent model to catch wrong stage ordering or a swapped serial source.

// File: rtl/sext_shreg_pkg.sv
// Package: shared operation type and mode decode for the sign-extending
// shift register. Assumes the control polarities given in the brief.
package sext_shreg_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2,
        OP_SEXT  = 2'd3
    } shreg_op_e;

    // Map the three mode controls onto one clocked operation.
    function automatic shreg_op_e decode_op(input logic stall,
                                            input logic shift_sel,
                                            input logic sext_n);
        shreg_op_e op;
        if (stall)
            op = OP_HOLD;
        else if (!shift_sel)
            op = OP_LOAD;
        else if (sext_n)
            op = OP_SHIFT;
        else
            op = OP_SEXT;
        return op;
    endfunction

endpackage

// File: rtl/shreg_ctl.sv
// Control decode: turns the mode pins into one operation, flags load mode
// for the pin logic, and picks the bit that enters the top stage on a
// shift. Assumes head_q is the current top-stage value.
module shreg_ctl
    import sext_shreg_pkg::*;
(
    input  logic      stall,
    input  logic      shift_sel,
    input  logic      sext_n,
    input  logic      src_sel,
    input  logic      ser_in0,
    input  logic      ser_in1,
    input  logic      head_q,
    output shreg_op_e op,
    output logic      load_mode,
    output logic      head_bit
);

    logic serial_bit;

    // Decode the operation and the load-mode flag.
    always_comb begin
        op        = decode_op(stall, shift_sel, sext_n);
        load_mode = (op == OP_LOAD);
    end

    // Pick the serial source, then replace it with the sign bit in sign-extend.
    always_comb begin
        serial_bit = src_sel ? ser_in1 : ser_in0;
        head_bit   = (op == OP_SEXT) ? head_q : serial_bit;
    end

endmodule

// File: rtl/shreg_stage.sv
// One register stage with asynchronous active-low clear. Each clock it
// holds, loads its parallel bit, or takes the bit shifted in from above.
module shreg_stage
    import sext_shreg_pkg::*;
(
    input  logic      clk,
    input  logic      clr_n,
    input  shreg_op_e op,
    input  logic      shift_in,
    input  logic      par_in,
    output logic      q
);

    // State update; clear overrides every operation.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= 1'b0;
        else begin
            case (op)
                OP_HOLD:  q <= q;
                OP_LOAD:  q <= par_in;
                OP_SHIFT,
                OP_SEXT:  q <= shift_in;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/shreg_pins.sv
// Pin stage: always offers the register contents on the data-out bus and
// drives only when the pins are switched on and the block is not loading.
module shreg_pins #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] q,
    input  logic             pin_off,
    input  logic             load_mode,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);

    logic drive;

    // One drive decision, fanned out to every pin.
    always_comb begin
        drive   = !pin_off && !load_mode;
        pin_out = q;
        pin_oe  = {WIDTH{drive}};
    end

endmodule

// File: rtl/sext_shreg.sv
// Top: a WIDTH-stage register that shifts toward bit 0, with sign extend,
// serial source select, parallel load over shared pins, and a serial tail
// output. Stage A is bit WIDTH-1 and stage H is bit 0. Assumes WIDTH >= 2.
module sext_shreg
    import sext_shreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             stall,
    input  logic             shift_sel,
    input  logic             sext_n,
    input  logic             src_sel,
    input  logic             ser_in0,
    input  logic             ser_in1,
    input  logic             pin_off,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic             tail_out
);

    localparam int TOP = WIDTH - 1;

    shreg_op_e        op;
    logic             load_mode;
    logic             head_bit;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] shift_in;

    shreg_ctl u_ctl (
        .stall     (stall),
        .shift_sel (shift_sel),
        .sext_n    (sext_n),
        .src_sel   (src_sel),
        .ser_in0   (ser_in0),
        .ser_in1   (ser_in1),
        .head_q    (q[TOP]),
        .op        (op),
        .load_mode (load_mode),
        .head_bit  (head_bit)
    );

    // Build the stage chain; the top stage takes the selected head bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == TOP) begin : g_head
            assign shift_in[i] = head_bit;
        end else begin : g_body
            assign shift_in[i] = q[i+1];
        end

        shreg_stage u_stage (
            .clk      (clk),
            .clr_n    (clr_n),
            .op       (op),
            .shift_in (shift_in[i]),
            .par_in   (pin_in[i]),
            .q        (q[i])
        );
    end

    shreg_pins #(.WIDTH(WIDTH)) u_pins (
        .q         (q),
        .pin_off   (pin_off),
        .load_mode (load_mode),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // Serial output is the bottom stage, independent of pin_off.
    assign tail_out = q[0];

endmodule

// File: rtl/sext_shreg_chk.sv
// Checker for sext_shreg: relates mode inputs to register contents and pin
// direction over time. Assumes it is bound onto the top module.
module sext_shreg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic             stall,
    input logic             shift_sel,
    input logic             sext_n,
    input logic             src_sel,
    input logic             ser_in0,
    input logic             ser_in1,
    input logic             pin_off,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe,
    input logic             tail_out
);

    // R1
    clear_zero_chk: assert property (@(negedge clk)
        !clr_n |-> (pin_out == '0));

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
        stall |=> $stable(pin_out));

    // R3
    shift_move_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!stall && shift_sel && sext_n) |=>
            (pin_out[WIDTH-2:0] == $past(pin_out[WIDTH-1:1])));

    // R4
    serial_src_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!stall && shift_sel && sext_n) |=>
            (pin_out[WIDTH-1] == $past(src_sel ? ser_in1 : ser_in0)));

    // R5
    sign_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!stall && shift_sel && !sext_n) |=>
            (pin_out == {$past(pin_out[WIDTH-1]), $past(pin_out[WIDTH-1:1])}));

    // R6
    par_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!stall && !shift_sel) |=> (pin_out == $past(pin_in)));

    // R7
    load_release_chk: assert property (@(negedge clk)
        (!stall && !shift_sel) |-> (pin_oe == '0));

    // R8
    off_release_chk: assert property (@(negedge clk)
        pin_off |-> (pin_oe == '0));

    // R9
    drive_on_chk: assert property (@(negedge clk)
        (!pin_off && (stall || shift_sel)) |-> (pin_oe == '1));

    // R10
    tail_match_chk: assert property (@(negedge clk)
        tail_out == pin_out[0]);

endmodule

bind sext_shreg sext_shreg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .stall     (stall),
    .shift_sel (shift_sel),
    .sext_n    (sext_n),
    .src_sel   (src_sel),
    .ser_in0   (ser_in0),
    .ser_in1   (ser_in1),
    .pin_off   (pin_off),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .tail_out  (tail_out)
);

// File: tb/sim_sext_shreg.sv
// Bench for sext_shreg: a vector table walked by one loop, then directed
// clear and corner tests, then random modes against a bench model.
module sim_sext_shreg;

    localparam int W      = 8;
    localparam int NVEC   = 12;
    localparam int NRAND  = 300;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         stall = 1'b1, shift_sel = 1'b1, sext_n = 1'b1, src_sel = 1'b0;
    logic         ser_in0 = 1'b0, ser_in1 = 1'b0, pin_off = 1'b0;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out, pin_oe;
    logic         tail_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    sext_shreg #(.WIDTH(W)) u0 (
        .clk(clk), .clr_n(clr_n), .stall(stall), .shift_sel(shift_sel),
        .sext_n(sext_n), .src_sel(src_sel), .ser_in0(ser_in0),
        .ser_in1(ser_in1), .pin_off(pin_off), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .tail_out(tail_out)
    );

    // Row: {req, stall, shift_sel, sext_n, src_sel, d0, d1, off, pin_in, exp_q, exp_oe}
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd6,  7'b0_0_1_0_0_0_0, 8'hA5, 8'hA5, 1'b0}, // R6 load
        {4'd2,  7'b1_0_1_0_0_0_0, 8'hFF, 8'hA5, 1'b1}, // R2 hold, pins ignored
        {4'd3,  7'b0_1_1_0_1_0_0, 8'h00, 8'hD2, 1'b1}, // R3 shift in d0=1
        {4'd4,  7'b0_1_1_1_0_1_0, 8'h00, 8'hE9, 1'b1}, // R4 src 1 picks d1
        {4'd4,  7'b0_1_1_1_1_0_0, 8'h00, 8'h74, 1'b1}, // R4 src 1 ignores d0
        {4'd5,  7'b0_1_0_0_1_1_0, 8'h00, 8'h3A, 1'b1}, // R5 sign 0 kept
        {4'd7,  7'b0_0_1_0_0_0_1, 8'h80, 8'h80, 1'b0}, // R7 load with pins off
        {4'd8,  7'b0_1_0_0_0_0_1, 8'h00, 8'hC0, 1'b0}, // R8 sext while off
        {4'd5,  7'b0_1_0_1_0_0_0, 8'h00, 8'hE0, 1'b1}, // R5 sign 1 kept
        {4'd8,  7'b0_1_1_0_0_0_1, 8'h00, 8'h70, 1'b0}, // R8 shift while off
        {4'd7,  7'b0_0_1_0_0_0_0, 8'h3C, 8'h3C, 1'b0}, // R7 load forces release
        {4'd2,  7'b1_0_1_0_0_0_1, 8'hC3, 8'h3C, 1'b0}  // R2 hold while off
    };

    // Compare one value and report a failure line on mismatch.
    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive a mode at the falling edge, let one rising edge pass, settle.
    task automatic step(input logic s, input logic ps, input logic se, input logic sr,
                        input logic a0, input logic a1, input logic off,
                        input logic [W-1:0] pin);
        @(negedge clk);
        stall = s; shift_sel = ps; sext_n = se; src_sel = sr;
        ser_in0 = a0; ser_in1 = a1; pin_off = off; pin_in = pin;
        @(posedge clk);
        #5;
    endtask

    // Bench model of the next register value, written from the requirements.
    function automatic logic [W-1:0] model_next(input logic [W-1:0] cur,
            input logic s, input logic ps, input logic se, input logic sr,
            input logic a0, input logic a1, input logic [W-1:0] pin);
        if (s)        return cur;
        if (!ps)      return pin;
        if (se)       return {(sr ? a1 : a0), cur[W-1:1]};
        return {cur[W-1], cur[W-1:1]};
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] mq;
        // R1: reset state after clear, before any clock edge
        #2 clr_n = 1'b0;
        #1;
        chk("R1 reset contents", pin_out, 8'h00);
        chk("R10 reset tail", {7'b0, tail_out}, 8'h00);
        chk("R9 reset drive", pin_oe, 8'hFF);
        @(negedge clk);
        clr_n = 1'b1;

        // Table walk
        for (int k = 0; k < NVEC; k++) begin
            logic [27:0] v;
            v = VEC[k];
            step(v[23], v[22], v[21], v[20], v[19], v[18], v[17], v[16:9]);
            chk($sformatf("R%0d row %0d contents", v[27:24], k), pin_out, v[8:1]);
            chk($sformatf("R%0d row %0d drive", v[27:24], k), pin_oe, {W{v[0]}});
            chk($sformatf("R10 row %0d tail", k), {7'b0, tail_out}, {7'b0, v[1]});
        end

        // R10: tail follows bit 0 while pins are off
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
        chk("R10 tail with pins off", {7'b0, tail_out}, 8'h01);
        chk("R8 released after load off", pin_oe, 8'h00);

        // R1: clear mid-cycle with no edge, pins still driving
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R9 hold drives", pin_oe, 8'hFF);
        #2 clr_n = 1'b0;
        #1;
        chk("R1 async clear", pin_out, 8'h00);
        chk("R8 clear keeps drive", pin_oe, 8'hFF);

        // R11: clear held across a load edge, load mode releases pins (R7)
        @(negedge clk);
        stall = 1'b0; shift_sel = 1'b0; pin_in = 8'hFF; pin_off = 1'b0;
        #1;
        chk("R7 load during clear releases", pin_oe, 8'h00);
        @(posedge clk);
        #5;
        chk("R11 clear beats load edge", pin_out, 8'h00);
        // Release clear and select a shift; first edge must shift in a 1
        @(negedge clk);
        clr_n = 1'b1;
        shift_sel = 1'b1; sext_n = 1'b1; src_sel = 1'b0; ser_in0 = 1'b1;
        @(posedge clk);
        #5;
        chk("R11 first edge after release", pin_out, 8'h80);

        // R5: repeated sign-extend of a negative value fills with ones
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h90);
        for (int k = 0; k < 3; k++)
            step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R5 arithmetic shift by 3", pin_out, 8'hF2);

        // Random modes against the bench model (R2 R3 R4 R5 R6 R7 R9 R10)
        mq = pin_out;
        for (int k = 0; k < NRAND; k++) begin
            logic [7:0] r;
            logic [W-1:0] pv;
            logic         loadm;
            r  = 8'($urandom);
            pv = W'($urandom);
            step(r[0] & r[1], r[2] | r[7], r[3], r[4], r[5], r[6], r[7] & r[1], pv);
            mq    = model_next(mq, r[0] & r[1], r[2] | r[7], r[3], r[4], r[5], r[6], pv);
            loadm = !(r[0] & r[1]) && !(r[2] | r[7]);
            chk($sformatf("R3 random %0d contents", k), pin_out, mq);
            chk($sformatf("R9 random %0d drive", k), pin_oe,
                {W{!(r[7] & r[1]) && !loadm}});
            chk($sformatf("R10 random %0d tail", k), {7'b0, tail_out}, {7'b0, mq[0]});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule